// File: doc/BRIEF.md
# Rational-Ratio Sample Rate Converter

This block changes the sample rate of a stream by a factor L/M. It needs no filter running at the L-times rate. It stands for an upsampler followed by a lowpass FIR and a downsampler. The output stream runs at L/M times the input rate. For each output, a phase register selects the subset of prototype coefficients that applies. It also decides how many new input samples must arrive first. One multiply-accumulate unit then walks the selected taps against the newest history entries, one tap per clock.

L, M and a start offset come from a configuration port. They are captured only by a restart strobe, which also empties the history. Setting L equal to M turns the block into a fractional delay line: the start offset shifts the output by offset/L of an input period. The input and output streams use valid/ready handshakes. The block accepts an input only while it is short of the samples needed for the next output. It holds an output until the output is taken.

Top module: `ratio_resampler`

## Requirements
- R1: After reset, `in_ready` and `out_valid` stay low until the first `restart` pulse.
- R2: Output n has the interpolated index t = n*M + S, where S is the start offset. With q = floor(t/L) and p = t mod L, the output equals the sum over j >= 0 of h(p + j*L) * x(q - j). Only terms with p + j*L < TAPS and q - j >= 0 are included. Here x(0) is the first input accepted after restart.
- R3: The prototype coefficient h(k), for 0 <= k < TAPS, is (((29*k + 7) mod 61) - 30) * 60 as a signed CW-bit value.
- R4: The full-precision sum is rounded by adding 2^(SHIFT-1) and shifting right arithmetically by SHIFT. It then saturates to the signed DW-bit range [-32768, 32767].
- R5: `cfg_l`, `cfg_m` and `cfg_start` are captured only in the cycle `restart` is high. Changing them at any other time has no effect on the outputs.
- R6: A restart clears every stored input sample and resets the phase. Samples accepted before the restart never contribute to later outputs.
- R7: With L = M and S in 1..L-1, output n is the prototype evaluated at offset S/L of a sample after input n. This makes the block a fractional-sample delay.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value.
- R9: `in_ready` and `out_valid` are never high in the same cycle. Each input is used by all outputs that depend on it, in arrival order.
- R10: In the cycle after a `restart` pulse, `out_valid` and `in_ready` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_l | input | LW | Interpolation factor L, 1..LMAX |
| cfg_m | input | MW | Decimation factor M, 1..MMAX |
| cfg_start | input | MW | Start offset S in interpolated-rate steps, 0..M-1 |
| restart | input | 1 | Captures the configuration and clears history and phase |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block wants an input sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_data | output | DW | Signed, rounded and saturated output sample |

## Verification
The stimulus patterns are an impulse, a ramp, an alternating-sign sequence and full-scale constants. The impulse shows the raw coefficient subset and the order in which it is applied for each phase. The ramp and the alternating pattern show whether the history lines up with the right taps at each output. The full-scale constants force both saturation limits. Ratios below one, above one and equal to one, with nonzero start offsets, separate phase stepping from input consumption. Back-to-back restarts, with large data before the restart and zeros after it, show whether history and configuration are handled at the strobe.

// File: rtl/rs_pkg.sv
// Package for the rational resampler.
// Holds the controller state type and the function that computes the
// prototype coefficients. Assumes a coefficient width of at least 12 bits.
package rs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_FILL,
        ST_MAC,
        ST_EMIT
    } rs_state_t;

    // Prototype tap value for index k; magnitude never exceeds 1800.
    function automatic int rs_coef(input int k);
        return (((29 * k + 7) % 61) - 30) * 60;
    endfunction

endpackage

// File: rtl/rs_history.sv
// Input history for the rational resampler.
// Keeps the most recent DEPTH samples, newest at position 0. A push shifts
// every entry one place older. A clear sets all entries to zero.
// The read port returns zero for positions at or beyond DEPTH.
module rs_history #(
    parameter int DW    = 16,
    parameter int DEPTH = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        push,
    input  logic signed [DW-1:0]        din,
    input  logic [$clog2(DEPTH)-1:0]    rd_idx,
    output logic signed [DW-1:0]        rd_data
);
    localparam int JW   = $clog2(DEPTH);
    localparam int VIEW = 2 ** JW;

    logic signed [DW-1:0] stage [DEPTH];
    logic signed [DW-1:0] view  [VIEW];

    // Newest entry: load on push, zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stage[0] <= '0;
        end else if (push) begin
            stage[0] <= din;
        end
    end

    // Older entries: each one takes its younger neighbour on push.
    for (genvar g = 1; g < DEPTH; g++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                stage[g] <= '0;
            end else if (push) begin
                stage[g] <= stage[g-1];
            end
        end
    end

    // Read view padded to a power of two, so every index is in range.
    for (genvar g = 0; g < VIEW; g++) begin : g_view
        if (g < DEPTH) begin : g_live
            assign view[g] = stage[g];
        end else begin : g_pad
            assign view[g] = '0;
        end
    end

    assign rd_data = view[rd_idx];

endmodule

// File: rtl/rs_mac.sv
// Shared multiply-accumulate and output stage.
// Adds one coefficient*sample product per enabled cycle into a wide
// accumulator. Rounds half-up at bit SHIFT and saturates to DW bits.
// Assumes ACCW is large enough that TAPS products cannot overflow.
module rs_mac #(
    parameter int DW    = 16,
    parameter int CW    = 12,
    parameter int TAPS  = 24,
    parameter int SHIFT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [CW-1:0] coef,
    input  logic signed [DW-1:0] sample,
    output logic signed [DW-1:0] result
);
    localparam int PRW  = DW + CW;
    localparam int ACCW = PRW + $clog2(TAPS) + 1;
    localparam logic signed [ACCW-1:0] YMAX = ACCW'((64'sd1 <<< (DW-1)) - 1);
    localparam logic signed [ACCW-1:0] YMIN = -ACCW'(64'sd1 <<< (DW-1));
    localparam logic signed [ACCW-1:0] HALF = ACCW'(64'sd1 <<< (SHIFT-1));

    logic signed [PRW-1:0]  prod;
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] rounded;
    logic signed [ACCW-1:0] scaled;

    assign prod = coef * sample;

    // Accumulator: cleared at the start of each output, adds one tap per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + ACCW'(prod);
        end
    end

    // Round half-up, scale down, and clamp to the output range.
    always_comb begin
        rounded = acc + HALF;
        scaled  = rounded >>> SHIFT;
        if (scaled > YMAX) begin
            result = YMAX[DW-1:0];
        end else if (scaled < YMIN) begin
            result = YMIN[DW-1:0];
        end else begin
            result = scaled[DW-1:0];
        end
    end

endmodule

// File: rtl/rs_ctrl.sv
// Phase and sequencing control for the rational resampler.
// Keeps the phase p in interpolated-rate steps. Each output adds M to it,
// and each subtraction of L asks for one more input sample. Once the needed
// samples are in, it walks tap addresses p, p+L, p+2L ... below TAPS
// against history positions 0, 1, 2 ... It then presents the result.
// Assumes 1 <= L <= LMAX <= TAPS and 1 <= M <= MMAX.
module rs_ctrl
    import rs_pkg::*;
#(
    parameter int TAPS = 24,
    parameter int LMAX = 8,
    parameter int MMAX = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          restart,
    input  logic [$clog2(LMAX+1)-1:0]     cfg_l,
    input  logic [$clog2(MMAX+1)-1:0]     cfg_m,
    input  logic [$clog2(MMAX+1)-1:0]     cfg_start,
    input  logic                          in_valid,
    input  logic                          out_ready,
    output logic                          in_ready,
    output logic                          push,
    output logic                          hist_clr,
    output logic                          acc_clr,
    output logic                          mac_en,
    output logic [$clog2(TAPS+LMAX+1)-1:0] tap_addr,
    output logic [$clog2(TAPS)-1:0]       hist_addr,
    output logic                          out_valid
);
    localparam int LW = $clog2(LMAX + 1);
    localparam int MW = $clog2(MMAX + 1);
    localparam int PW = $clog2(LMAX + MMAX + 1);
    localparam int NW = $clog2(LMAX + MMAX + 2);
    localparam int KW = $clog2(TAPS + LMAX + 1);
    localparam int JW = $clog2(TAPS);

    rs_state_t      state;
    logic [LW-1:0]  l_r;
    logic [MW-1:0]  m_r;
    logic [PW-1:0]  ph;
    logic [NW-1:0]  need;
    logic [KW-1:0]  k;
    logic [JW-1:0]  j;
    logic [KW-1:0]  k_next;
    logic           fill_done;

    assign k_next    = k + KW'(l_r);
    assign fill_done = (state == ST_FILL) && (need == '0);

    // Handshake and datapath strobes decoded from the state.
    always_comb begin
        in_ready  = (state == ST_FILL) && (need != '0);
        push      = in_ready && in_valid;
        hist_clr  = restart;
        acc_clr   = restart || fill_done;
        mac_en    = (state == ST_MAC);
        out_valid = (state == ST_EMIT);
        tap_addr  = k;
        hist_addr = j;
    end

    // Sequencer: restart capture, phase stepping, filling, tap walk, emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            l_r   <= LW'(1);
            m_r   <= MW'(1);
            ph    <= '0;
            need  <= '0;
            k     <= '0;
            j     <= '0;
        end else if (restart) begin
            state <= ST_STEP;
            l_r   <= cfg_l;
            m_r   <= cfg_m;
            ph    <= PW'(cfg_start);
            need  <= NW'(1);
            k     <= '0;
            j     <= '0;
        end else begin
            case (state)
                ST_STEP: begin
                    if (ph >= PW'(l_r)) begin
                        ph   <= ph - PW'(l_r);
                        need <= need + NW'(1);
                    end else begin
                        state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (need == '0) begin
                        state <= ST_MAC;
                        k     <= KW'(ph);
                        j     <= '0;
                    end else if (in_valid) begin
                        need <= need - NW'(1);
                    end
                end
                ST_MAC: begin
                    k <= k_next;
                    j <= j + JW'(1);
                    if (k_next >= KW'(TAPS)) begin
                        state <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        ph    <= ph + PW'(m_r);
                        state <= ST_STEP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ratio_resampler.sv
// Rational-ratio sample rate converter, top level.
// Ties the phase controller, the input history, the coefficient table and
// the shared multiply-accumulate together. The coefficient table holds the
// prototype at the interpolated rate. It is computed from rs_coef and padded
// with zeros to a power-of-two depth.
// Assumes LMAX <= TAPS and CW >= 12.
module ratio_resampler
    import rs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 12,
    parameter int TAPS  = 24,
    parameter int LMAX  = 8,
    parameter int MMAX  = 15,
    parameter int SHIFT = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(LMAX+1)-1:0]     cfg_l,
    input  logic [$clog2(MMAX+1)-1:0]     cfg_m,
    input  logic [$clog2(MMAX+1)-1:0]     cfg_start,
    input  logic                          restart,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic signed [DW-1:0]          in_data,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic signed [DW-1:0]          out_data
);
    localparam int KW   = $clog2(TAPS + LMAX + 1);
    localparam int JW   = $clog2(TAPS);
    localparam int ROMD = 2 ** KW;

    logic                 push;
    logic                 hist_clr;
    logic                 acc_clr;
    logic                 mac_en;
    logic [KW-1:0]        tap_addr;
    logic [JW-1:0]        hist_addr;
    logic signed [DW-1:0] hist_data;
    logic signed [CW-1:0] coef;
    logic signed [CW-1:0] rom [ROMD];

    // Coefficient table computed from the prototype function.
    for (genvar g = 0; g < ROMD; g++) begin : g_rom
        if (g < TAPS) begin : g_tap
            assign rom[g] = CW'(rs_coef(g));
        end else begin : g_zero
            assign rom[g] = '0;
        end
    end

    assign coef = rom[tap_addr];

    rs_ctrl #(
        .TAPS (TAPS),
        .LMAX (LMAX),
        .MMAX (MMAX)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .cfg_l     (cfg_l),
        .cfg_m     (cfg_m),
        .cfg_start (cfg_start),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .push      (push),
        .hist_clr  (hist_clr),
        .acc_clr   (acc_clr),
        .mac_en    (mac_en),
        .tap_addr  (tap_addr),
        .hist_addr (hist_addr),
        .out_valid (out_valid)
    );

    rs_history #(
        .DW    (DW),
        .DEPTH (TAPS)
    ) i_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hist_clr),
        .push    (push),
        .din     (in_data),
        .rd_idx  (hist_addr),
        .rd_data (hist_data)
    );

    rs_mac #(
        .DW    (DW),
        .CW    (CW),
        .TAPS  (TAPS),
        .SHIFT (SHIFT)
    ) i_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .en     (mac_en),
        .coef   (coef),
        .sample (hist_data),
        .result (out_data)
    );

endmodule

// File: rtl/rs_checker.sv
// Protocol checker for the resampler's port behaviour, bound to the top.
// Tracks whether a restart has happened since reset and checks idle
// behaviour, output holding, handshake exclusivity and restart quieting.
module rs_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          restart,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data
);
    logic started;

    // Remembers whether a restart has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (restart) begin
            started <= 1'b1;
        end
    end

    a_r1_idle_until_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!in_ready && !out_valid));

    a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !restart) |=> out_valid);

    a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !restart) |=> $stable(out_data));

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!in_ready && !out_valid));

endmodule

bind ratio_resampler rs_checker #(.DW(DW)) i_rs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_ratio_resampler.sv
// Self-checking bench for ratio_resampler. A table of configurations and
// stimulus patterns is walked by one loop. Each output is compared with a
// bit-true model written from the requirements. Directed tests for reset,
// restart, ignored configuration and history clearing follow the table.
module test_ratio_resampler;
    localparam int DW    = 16;
    localparam int TAPS  = 24;
    localparam int SHIFT = 10;
    localparam int ROWS  = 12;
    localparam int LIMIT = 150000;

    // Columns: L, M, S, pattern, inputs, backpressure
    localparam int TBL [ROWS][6] = '{
        '{3, 4, 0, 0, 12, 0},
        '{3, 4, 0, 1, 12, 0},
        '{5, 3, 0, 1, 10, 1},
        '{5, 3, 2, 2, 10, 0},
        '{4, 4, 1, 1,  8, 0},
        '{4, 4, 3, 2,  8, 1},
        '{1, 1, 0, 1,  6, 0},
        '{1, 5, 4, 1, 20, 0},
        '{8, 1, 0, 0,  4, 0},
        '{2, 15, 0, 2, 30, 1},
        '{3, 2, 0, 3,  8, 0},
        '{3, 2, 1, 4,  8, 0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [3:0]           cfg_l = 4'd1;
    logic [3:0]           cfg_m = 4'd1;
    logic [3:0]           cfg_start = 4'd0;
    logic                 restart = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic signed [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int overlap = 0;

    ratio_resampler i_ratio_resampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_l     (cfg_l),
        .cfg_m     (cfg_m),
        .cfg_start (cfg_start),
        .restart   (restart),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    always #4 clk = ~clk;

    // Watchdog and a port monitor for R9.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && in_ready && out_valid) overlap <= overlap + 1;
        if (cycles > LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer than %0d", cycles, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // R3: prototype tap values.
    function automatic longint coef_model(input int k);
        return longint'((((29 * k + 7) % 61) - 30) * 60);
    endfunction

    function automatic longint pat(input int sel, input int i);
        case (sel)
            0: return (i == 0) ? 64'sd1000 : 64'sd0;
            1: return longint'(i * 37 - 200);
            2: return (i % 2 == 1) ? -longint'(300 + i * 11) : longint'(300 + i * 11);
            3: return 64'sd32767;
            4: return -64'sd32768;
            default: return 64'sd0;
        endcase
    endfunction

    // R2 and R4: expected output n.
    function automatic longint model(input int l, input int m, input int s,
                                     input int sel, input int n);
        int t = n * m + s;
        int q = t / l;
        int p = t % l;
        longint acc = 0;
        longint v;
        for (int jj = 0; (p + jj * l < TAPS) && (q - jj >= 0); jj++) begin
            acc += coef_model(p + jj * l) * pat(sel, q - jj);
        end
        v = (acc + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_restart(input int l, input int m, input int s);
        @(negedge clk);
        cfg_l = 4'(l);
        cfg_m = 4'(m);
        cfg_start = 4'(s);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        // R10: quiet in the cycle after restart
        check(!out_valid && !in_ready, "R10", longint'({out_valid, in_ready}), 0);
    endtask

    task automatic drive(input int sel, input int nin, input int bp);
        for (int i = 0; i < nin; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = DW'(pat(sel, i));
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            if (bp != 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect(input int l, input int m, input int s, input int sel,
                           input int nexp, input int bp, input string req);
        int n = 0;
        int tick = 0;
        bit waiting = 0;
        logic signed [DW-1:0] held = '0;
        while (n < nexp) begin
            @(negedge clk);
            tick++;
            out_ready = (bp == 0) || (tick % 3 != 0);
            if (out_valid && waiting) begin
                // R8: data held while stalled
                check(out_data == held, "R8", longint'(out_data), longint'(held));
            end
            waiting = 0;
            if (out_valid && out_ready) begin
                check(longint'(out_data) == model(l, m, s, sel, n), req,
                      longint'(out_data), model(l, m, s, sel, n));
                n++;
            end else if (out_valid) begin
                waiting = 1;
                held = out_data;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_row(input int l, input int m, input int s, input int sel,
                           input int nin, input int bp, input string req);
        int nexp = 0;
        while ((nexp * m + s) / l < nin) nexp++;
        fork
            drive(sel, nin, bp);
            collect(l, m, s, sel, nexp, bp, req);
        join
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: idle after reset, before any restart
        check(!out_valid && !in_ready, "R1", longint'({out_valid, in_ready}), 0);

        // Table walk: R2 general ratios, R3 via impulse, R4 via full-scale rows,
        // R7 via L = M rows, R8 via backpressure rows.
        for (int r = 0; r < ROWS; r++) begin
            string req;
            if (TBL[r][0] == TBL[r][1] && TBL[r][2] != 0) req = "R7";
            else if (TBL[r][3] >= 3) req = "R4";
            else if (TBL[r][3] == 0) req = "R3";
            else req = "R2";
            do_restart(TBL[r][0], TBL[r][1], TBL[r][2]);
            run_row(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], TBL[r][5], req);
        end
        // R9: handshakes never overlapped during the table
        check(overlap == 0, "R9", longint'(overlap), 0);

        // R5: changing configuration without restart has no effect
        do_restart(3, 4, 1);
        @(negedge clk);
        cfg_l = 4'd7;
        cfg_m = 4'd2;
        cfg_start = 4'd0;
        run_row(3, 4, 1, 1, 12, 0, "R5");

        // R6: history from before a restart does not leak into later outputs
        do_restart(1, 1, 0);
        run_row(1, 1, 0, 3, 5, 0, "R6");
        do_restart(1, 1, 0);
        run_row(1, 1, 0, 5, 4, 0, "R6");

        // R6: restart with inputs half consumed, then a fresh impulse stream
        do_restart(2, 3, 0);
        in_valid = 1'b1;
        in_data = 16'sd20000;
        repeat (6) @(negedge clk);
        in_valid = 1'b0;
        do_restart(2, 3, 1);
        run_row(2, 3, 1, 0, 9, 0, "R6");

        check(overlap == 0, "R9", longint'(overlap), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule